// File: doc/BRIEF.md
# Packet-Chain OTP Read Controller

This block sits between a register bus and a one-time-programmable word array that holds a chain of packets. Packet 0 starts at word 0. Each packet is one header word followed by a payload. The header carries a size value N, the payload is N+1 words long, and the next packet begins right after the payload. Software places a word offset in the mode register and then issues a read command. The controller walks the chain by header sizes until it reaches the packet whose word range holds that offset. It then copies that packet's header and payload into local buffers, and a busy flag stays set until the copy is done.

After the load, software reads the header from one register and the payload from a data port. A pointer register positions the data port. Writing zero to the pointer rewinds it, and each read of the data port returns the next payload word. A zero size field ends the chain. A request that lies beyond that end, or beyond the array, returns a zero header and raises an error flag. The array sits outside the block as a synchronous ROM: it takes an address and returns the word one clock later.

Top module: `otpc_packet_reader`

## Requirements
- R1: After reset, the mode, status, header, pointer and data-port registers all read 0.
- R2: The mode register at byte offset 0x04 stores all 32 written bits and reads them back. Bits 31:16 hold the requested word offset.
- R3: A write to the control register (0x00) with bit 6 set, while idle, starts a load, and status bit 6 (0x0C) reads 1 from the next cycle until the load ends. A control write with bit 6 clear, or any command while busy, has no effect.
- R4: Header bits 15:8 hold N. The payload has N+1 words, starting at the packet's start + 1, and the next packet starts at start + N + 2, with packet 0 at word 0.
- R5: A requested offset anywhere in [start of packet k, start of packet k+1) loads packet k, and its header word reads back at 0x20.
- R6: After a load the payload pointer is 0. Each read of the data port (0x24) returns the payload word at the pointer and advances the pointer by one.
- R7: Writing v to the pointer register (0x08) sets the pointer to v, clamped to the payload length. Writing 0 rewinds to the first payload word. Reading 0x08 returns the pointer.
- R8: Once every payload word has been read, the pointer stays at the payload length, and further data-port reads return 0.
- R9: A request past the end-marker header (size field 0) or past the array limit loads a zero header and an empty payload, clears busy, and sets status bit 0.
- R10: The error flag is cleared by the next load that finds a packet.
- R11: While busy, the array address stays below the array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| otp_addr | output | ADDR_W | Word address to the array |
| otp_rdata | input | 32 | Array word, valid one cycle after otp_addr |

## Verification
Read data is combinational, so the bench samples bus_rdata in the same cycle it presents a read, before the edge. The pointer advance from a data-port read shows up on the next access. Status bit 6 is due the cycle after the edge that takes the command write. The bench reads it one cycle later, which is still well inside the minimum two-cycle header walk. Load length depends on the chain, so completion is checked by polling status with a bounded count, and the header and payload checks run only after busy has dropped.

// File: rtl/otpc_pkg.sv
// Shared register offsets, bit positions and walker state encoding.
package otpc_pkg;
    localparam logic [5:0] OFS_CTRL = 6'h00;
    localparam logic [5:0] OFS_MODE = 6'h04;
    localparam logic [5:0] OFS_PTR  = 6'h08;
    localparam logic [5:0] OFS_STAT = 6'h0C;
    localparam logic [5:0] OFS_HDR  = 6'h20;
    localparam logic [5:0] OFS_DATA = 6'h24;
    localparam int CMD_BIT  = 6;
    localparam int BUSY_BIT = 6;
    localparam int ERR_BIT  = 0;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_FETCH,
        WK_EVAL,
        WK_LOAD
    } walk_state_e;
endpackage

// File: rtl/otpc_walker.sv
// Walks the packet chain from word 0 to the packet covering req_addr.
// It then streams that packet's payload into the buffer through fill_*.
// Assumes a synchronous array: the word for otp_addr arrives next cycle.
module otpc_walker #(
    parameter int OTP_WORDS = 2816,
    parameter int ADDR_W    = 12,
    parameter int LEN_W     = 9,
    parameter int IDX_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       req_addr,
    input  logic [31:0]       otp_rdata,
    output logic [ADDR_W-1:0] otp_addr,
    output logic              busy,
    output logic              err,
    output logic [31:0]       hdr,
    output logic [LEN_W-1:0]  plen,
    output logic              done,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [31:0]       fill_data
);
    import otpc_pkg::*;

    localparam int CW = 17;

    walk_state_e      state;
    logic [CW-1:0]    cur;
    logic [CW-1:0]    base;
    logic [15:0]      req_q;
    logic [LEN_W-1:0] iss;
    logic [LEN_W-1:0] len_q;
    logic             fill_vld;
    logic [IDX_W-1:0] fill_idx_q;
    logic [7:0]       size_n;
    logic [CW-1:0]    nxt;
    logic [LEN_W-1:0] iss_cl;
    logic [CW-1:0]    load_addr;

    // Decode the header size and the start of the following packet.
    always_comb begin
        size_n = otp_rdata[15:8];
        nxt    = cur + CW'(size_n) + CW'(2);
    end

    // Choose the array address: header walk or payload issue.
    always_comb begin
        iss_cl    = (iss == len_q) ? (iss - LEN_W'(1)) : iss;
        load_addr = base + CW'(iss_cl);
        if (state == WK_LOAD) otp_addr = load_addr[ADDR_W-1:0];
        else                  otp_addr = cur[ADDR_W-1:0];
    end

    // Main walk / load sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WK_IDLE;
            cur        <= '0;
            base       <= '0;
            req_q      <= '0;
            iss        <= '0;
            len_q      <= '0;
            fill_vld   <= 1'b0;
            fill_idx_q <= '0;
            hdr        <= '0;
            plen       <= '0;
            err        <= 1'b0;
            done       <= 1'b0;
        end else begin
            done     <= 1'b0;
            fill_vld <= 1'b0;
            case (state)
                WK_IDLE: begin
                    if (start) begin
                        req_q <= req_addr;
                        cur   <= '0;
                        err   <= 1'b0;
                        state <= WK_FETCH;
                    end
                end
                WK_FETCH: state <= WK_EVAL;
                WK_EVAL: begin
                    if (size_n == 8'd0 || nxt > CW'(OTP_WORDS)) begin
                        hdr   <= '0;
                        plen  <= '0;
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= WK_IDLE;
                    end else if ({1'b0, req_q} < nxt) begin
                        hdr   <= otp_rdata;
                        len_q <= LEN_W'(size_n) + LEN_W'(1);
                        base  <= cur + CW'(1);
                        iss   <= '0;
                        state <= WK_LOAD;
                    end else if (nxt >= CW'(OTP_WORDS)) begin
                        hdr   <= '0;
                        plen  <= '0;
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= WK_IDLE;
                    end else begin
                        cur   <= nxt;
                        state <= WK_FETCH;
                    end
                end
                WK_LOAD: begin
                    if (iss < len_q) begin
                        fill_vld   <= 1'b1;
                        fill_idx_q <= iss[IDX_W-1:0];
                        iss        <= iss + LEN_W'(1);
                    end
                    if (fill_vld && (LEN_W'(fill_idx_q) == len_q - LEN_W'(1))) begin
                        plen     <= len_q;
                        done     <= 1'b1;
                        fill_vld <= 1'b0;
                        state    <= WK_IDLE;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // Present buffer writes for words returned by the array.
    always_comb begin
        busy      = (state != WK_IDLE);
        fill_we   = fill_vld;
        fill_idx  = fill_idx_q;
        fill_data = otp_rdata;
    end
endmodule

// File: rtl/otpc_payload_buf.sv
// Holds the payload of the last loaded packet and the read pointer.
// A finished load sets the length and rewinds the pointer. Software can
// set the pointer (clamped to the length), and data-port reads advance it.
module otpc_payload_buf #(
    parameter int PAY_MAX = 256,
    parameter int LEN_W   = 9,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [31:0]      fill_data,
    input  logic             load_done,
    input  logic [LEN_W-1:0] load_len,
    input  logic             ptr_we,
    input  logic [31:0]      ptr_wdata,
    input  logic             pop,
    output logic [31:0]      rd_word,
    output logic [LEN_W-1:0] ptr_o,
    output logic [LEN_W-1:0] len_o
);
    logic [31:0]      mem [PAY_MAX];
    logic [LEN_W-1:0] ptr_q;
    logic [LEN_W-1:0] len_q;

    // Payload storage, written only while a load streams in.
    always_ff @(posedge clk) begin
        if (fill_we) mem[fill_idx] <= fill_data;
    end

    // Pointer and length update; load completion takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
        end else if (load_done) begin
            len_q <= load_len;
            ptr_q <= '0;
        end else if (ptr_we) begin
            ptr_q <= (ptr_wdata >= 32'(len_q)) ? len_q : ptr_wdata[LEN_W-1:0];
        end else if (pop && (ptr_q < len_q)) begin
            ptr_q <= ptr_q + LEN_W'(1);
        end
    end

    // Data-port view: the current word, or zero past the end.
    always_comb begin
        rd_word = (ptr_q < len_q) ? mem[ptr_q[IDX_W-1:0]] : 32'd0;
        ptr_o   = ptr_q;
        len_o   = len_q;
    end
endmodule

// File: rtl/otpc_packet_reader.sv
// Top of the packet-chain OTP read controller: register decode, mode
// register, and read mux over the walker and payload buffer.
// Assumes one register access per cycle and combinational read data.
module otpc_packet_reader #(
    parameter int OTP_WORDS = 2816,
    parameter int ADDR_W    = 12,
    parameter int PAY_MAX   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [ADDR_W-1:0] otp_addr,
    input  logic [31:0]       otp_rdata
);
    import otpc_pkg::*;

    localparam int LEN_W = $clog2(PAY_MAX + 1);
    localparam int IDX_W = $clog2(PAY_MAX);

    logic [31:0]      mode_q;
    logic             wr_hit_ctrl, wr_hit_mode, wr_hit_ptr, rd_hit_data;
    logic             start;
    logic             w_busy, w_err, w_done, f_we;
    logic [31:0]      w_hdr, f_data, pb_word;
    logic [LEN_W-1:0] w_plen, pb_ptr, pb_len;
    logic [IDX_W-1:0] f_idx;

    // Decode register hits for this cycle's access.
    always_comb begin
        wr_hit_ctrl = bus_en && bus_we && (bus_addr == OFS_CTRL);
        wr_hit_mode = bus_en && bus_we && (bus_addr == OFS_MODE);
        wr_hit_ptr  = bus_en && bus_we && (bus_addr == OFS_PTR);
        rd_hit_data = bus_en && !bus_we && (bus_addr == OFS_DATA);
        start       = wr_hit_ctrl && bus_wdata[CMD_BIT] && !w_busy;
    end

    // Mode register keeps every written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (wr_hit_mode) mode_q <= bus_wdata;
    end

    otpc_walker #(
        .OTP_WORDS(OTP_WORDS), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) walker_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(mode_q[31:16]),
        .otp_rdata(otp_rdata), .otp_addr(otp_addr), .busy(w_busy),
        .err(w_err), .hdr(w_hdr), .plen(w_plen), .done(w_done),
        .fill_we(f_we), .fill_idx(f_idx), .fill_data(f_data)
    );

    otpc_payload_buf #(
        .PAY_MAX(PAY_MAX), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) pbuf_i (
        .clk(clk), .rst_n(rst_n), .fill_we(f_we), .fill_idx(f_idx),
        .fill_data(f_data), .load_done(w_done), .load_len(w_plen),
        .ptr_we(wr_hit_ptr), .ptr_wdata(bus_wdata), .pop(rd_hit_data),
        .rd_word(pb_word), .ptr_o(pb_ptr), .len_o(pb_len)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_PTR:  bus_rdata = 32'(pb_ptr);
            OFS_STAT: begin
                bus_rdata[BUSY_BIT] = w_busy;
                bus_rdata[ERR_BIT]  = w_err;
            end
            OFS_HDR:  bus_rdata = w_hdr;
            OFS_DATA: bus_rdata = pb_word;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/otpc_reader_chk.sv
// Property checker for otpc_packet_reader, attached by bind below.
module otpc_reader_chk #(
    parameter int OTP_WORDS = 2816,
    parameter int ADDR_W    = 12,
    parameter int LEN_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [5:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       mode,
    input logic              busy,
    input logic              err,
    input logic [31:0]       hdr,
    input logic [LEN_W-1:0]  ptr,
    input logic [LEN_W-1:0]  len,
    input logic [ADDR_W-1:0] otp_addr
);
    import otpc_pkg::*;

    logic cmd_wr, data_rd;
    always_comb begin
        cmd_wr  = bus_en && bus_we && (bus_addr == OFS_CTRL) && bus_wdata[CMD_BIT];
        data_rd = bus_en && !bus_we && (bus_addr == OFS_DATA);
    end

    assert_busy_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_wr) |=> !busy);
    assert_mode_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == OFS_MODE) |=> (mode == $past(bus_wdata)));
    assert_pop_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !busy && ptr < len) |=> (ptr == $past(ptr) + LEN_W'(1)));
    assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= len);
    assert_past_end_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && ptr >= len) |-> (bus_rdata == 32'd0));
    assert_err_zero_hdr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (hdr == 32'd0));
    assert_otp_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(otp_addr) < OTP_WORDS));
endmodule

bind otpc_packet_reader otpc_reader_chk #(
    .OTP_WORDS(OTP_WORDS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode(mode_q), .busy(w_busy), .err(w_err), .hdr(w_hdr),
    .ptr(pb_ptr), .len(pb_len), .otp_addr(otp_addr)
);

// File: tb/otpc_packet_reader_tb_top.sv
module otpc_packet_reader_tb_top;
    localparam int OTP_WORDS = 2816;
    localparam int ADDR_W    = 12;
    localparam int NVEC      = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [ADDR_W-1:0] otp_addr;
    logic [31:0]       otp_rdata = '0;
    logic [31:0]       rom [OTP_WORDS];

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    otpc_packet_reader dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .otp_addr(otp_addr), .otp_rdata(otp_rdata)
    );

    // Synchronous array model.
    always @(posedge clk) otp_rdata <= rom[otp_addr];

    // Packet chain: starts, sizes, then an end marker at word 274.
    localparam int PK_START[4] = '{0, 5, 8, 17};
    localparam int PK_N[4]     = '{3, 1, 7, 255};

    function automatic logic [31:0] hv(int k, int n);
        return {16'(k), 8'(n), 8'h3C};
    endfunction
    function automatic logic [31:0] pw(int s, int j);
        return 32'((s << 12) | j);
    endfunction

    // Vector table: requested offset, expected packet index (-1 = error).
    localparam int V_REQ[NVEC] = '{0, 4, 3, 5, 7, 8, 16, 17, 273, 274, 2000};
    localparam int V_PK[NVEC]  = '{0, 0, 0, 1, 1, 2, 2, 3, 3, -1, -1};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] s;
        int k;
        s = 32'h40;
        for (k = 0; k < 2000 && s[6]; k++) brd(6'h0C, s);
        chk(req, 32'(s[6]), 32'd0);
    endtask

    task automatic start_load(int req);
        logic [31:0] s;
        bwr(6'h04, {16'(req), 16'h00A5});
        bwr(6'h00, 32'h40);
        brd(6'h0C, s);
        chk("R3 busy after command", 32'(s[6]), 32'd1);
        wait_idle("R3 busy clears");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < OTP_WORDS; i++) rom[i] = '0;
        for (int k = 0; k < 4; k++) begin
            rom[PK_START[k]] = hv(k, PK_N[k]);
            for (int j = 0; j <= PK_N[k]; j++) rom[PK_START[k] + 1 + j] = pw(PK_START[k], j);
        end

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        brd(6'h0C, v); chk("R1 status", v, 32'd0);
        brd(6'h04, v); chk("R1 mode", v, 32'd0);
        brd(6'h20, v); chk("R1 header", v, 32'd0);
        brd(6'h08, v); chk("R1 pointer", v, 32'd0);
        brd(6'h24, v); chk("R1 data", v, 32'd0);

        // R2: mode readback
        bwr(6'h04, 32'hDEAD_BEEF);
        brd(6'h04, v); chk("R2 mode readback", v, 32'hDEAD_BEEF);

        // R3: control write without bit 6 does nothing
        bwr(6'h00, 32'hFFFF_FFBF);
        brd(6'h0C, v); chk("R3 no start without bit 6", v, 32'd0);

        // Vector walk: R4 R5 R6 R8 R9
        for (int t = 0; t < NVEC; t++) begin
            start_load(V_REQ[t]);
            if (V_PK[t] < 0) begin
                brd(6'h0C, v); chk("R9 error flag", v, 32'd1);
                brd(6'h20, v); chk("R9 zero header", v, 32'd0);
                brd(6'h24, v); chk("R9 empty payload", v, 32'd0);
            end else begin
                brd(6'h0C, v); chk("R10 no error", v, 32'd0);
                brd(6'h20, v); chk("R5 header", v, hv(V_PK[t], PK_N[V_PK[t]]));
                for (int j = 0; j <= PK_N[V_PK[t]]; j++) begin
                    brd(6'h24, v); chk("R4 R6 payload word", v, pw(PK_START[V_PK[t]], j));
                end
                brd(6'h24, v); chk("R8 read past end", v, 32'd0);
                brd(6'h08, v); chk("R8 pointer held", v, 32'(PK_N[V_PK[t]] + 1));
            end
        end

        // R10: error from the last vector is cleared by a good load
        start_load(9);
        brd(6'h0C, v); chk("R10 error cleared", v, 32'd0);

        // R7: pointer positioning on packet 2 (8 words)
        bwr(6'h08, 32'd3);
        brd(6'h08, v); chk("R7 pointer set", v, 32'd3);
        brd(6'h24, v); chk("R7 word at 3", v, pw(8, 3));
        bwr(6'h08, 32'd100);
        brd(6'h08, v); chk("R7 pointer clamp", v, 32'd8);
        brd(6'h24, v); chk("R8 zero at clamp", v, 32'd0);
        bwr(6'h08, 32'd0);
        brd(6'h24, v); chk("R7 rewind word 0", v, pw(8, 0));
        brd(6'h24, v); chk("R6 next word 1", v, pw(8, 1));

        // R3: command while busy is ignored (request for packet 0 dropped)
        bwr(6'h04, {16'd17, 16'h0});
        bwr(6'h00, 32'h40);
        bwr(6'h04, {16'd0, 16'h0});
        bwr(6'h00, 32'h40);
        wait_idle("R3 busy clears");
        brd(6'h20, v); chk("R3 busy command ignored", v, hv(3, 255));
        brd(6'h04, v); chk("R2 mode updated while busy", v, 32'd0);

        // R1: reset returns registers to zero
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        brd(6'h20, v); chk("R1 header after reset", v, 32'd0);
        brd(6'h24, v); chk("R1 data after reset", v, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule